// File: doc/BRIEF.md
# SPI Master with FIFO-Tied Slave Select

This block is a register-programmed serial-peripheral master. Software picks a frame size from 4 to 16 bits, a clock polarity and phase, a clock divider and one slave line, then enables the master and writes frames into a transmit FIFO. Every transmitted frame is shifted out MSB first while a frame is shifted in from MISO, and the received word is pushed, right-justified, into a receive FIFO that software reads through the same data register.

Slave select is not a software-held bit. It is asserted when a frame is taken from the transmit FIFO, and released once a frame finishes and no further frame is waiting. With clock phase 1, select stays low across back-to-back frames for as long as the FIFO keeps supplying them. With clock phase 0, select is forced high for a gap between every pair of frames. Software that needs one long select window must keep the transmit FIFO from running dry.

An interrupt line combines two masked causes: the transmit level at or below a programmable threshold, and a full receive FIFO.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, ss_n is all ones, sclk is 0, irq is 0, both FIFO levels read 0, the control register reads 0x0007 and the status register reads 0x0006.
- R2: Control bits 3:0 hold the frame size minus one. A value below 3 gives 4-bit frames. Each frame sends the low bits of the written word MSB first and returns the received bits right-justified through the data register (word address 10).
- R3: Control bit 7 sets the SCLK idle level. With control bit 6 clear, the first bit is on MOSI when select asserts and both sides sample on leading edges. With bit 6 set, both sides sample on trailing edges.
- R4: Each SCLK half period lasts baud/2 system clocks, with an odd baud value rounded down. A baud value of 0 or 1 stops transfers: queued frames stay queued and select never asserts.
- R5: Only one ss_n line can be low at a time, and it is the line whose bit is set in the slave-select register (word address 2). A write to that register with more than one bit set is ignored.
- R6: With clock phase 1, select stays asserted from the first frame to the last of a run of queued frames. It is released once after the last frame completes with the transmit FIFO empty.
- R7: With clock phase 0, select goes high for at least one SCLK half period between consecutive frames, even while frames are queued.
- R8: Status (word address 8) bits: 0 busy, 1 TX not full, 2 TX empty, 3 RX not empty, 4 RX full, 5 RX overflow.
- R9: Interrupt status (word address 9) bit 0 is (TX level <= threshold) AND mask bit 0. Bit 4 is (RX full) AND mask bit 4. irq is the OR of the two. The threshold is at word address 4 and the mask at word address 5.
- R10: The TX level (word address 6) and the RX level (word address 7) count queued frames. A push into a full TX FIFO is dropped.
- R11: When a frame completes with the RX FIFO full, its word is dropped, the stored words are unchanged, and status bit 5 is set.
- R12: While the master is enabled, writes to the control register (address 0) and the baud register (address 3) are ignored.
- R13: Writing 0 to the enable register (address 1) aborts any frame, flushes both FIFOs, clears the overflow flag and returns SCLK to its idle level and ss_n to all ones. Data writes while disabled are ignored.
- R14: Busy reads 1 whenever select is asserted or the TX FIFO holds a frame, and reads 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX at the data address) |
| reg_addr | input | 4 | Word address of the register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from reg_addr |
| irq | output | 1 | Masked interrupt request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NSEL | Active-low slave selects |

## Verification
The hardest conditions to reach from the ports are the receive overflow and the select behaviour across back-to-back frames. Both need the transmit FIFO to keep supplying frames while the engine is running. The bench reaches them by writing a burst of frames faster than the serial side drains them, and by never reading the receive side until nine frames have completed. A behavioural slave on SCLK keeps its own bit log and returns a known word, so each clock mode is checked from both directions. A counter on select releases, together with the measured high time between frames, separates the phase-0 behaviour from the phase-1 behaviour.

// File: rtl/spim_pkg.sv
package spim_pkg;
    localparam int DW = 16;
    localparam int CW = DW - 1;

    localparam logic [3:0] A_CTRL   = 4'd0;
    localparam logic [3:0] A_EN     = 4'd1;
    localparam logic [3:0] A_SEL    = 4'd2;
    localparam logic [3:0] A_BAUD   = 4'd3;
    localparam logic [3:0] A_THR    = 4'd4;
    localparam logic [3:0] A_MASK   = 4'd5;
    localparam logic [3:0] A_TXLVL  = 4'd6;
    localparam logic [3:0] A_RXLVL  = 4'd7;
    localparam logic [3:0] A_STATUS = 4'd8;
    localparam logic [3:0] A_ISTAT  = 4'd9;
    localparam logic [3:0] A_DATA   = 4'd10;

    localparam int C_CPHA = 6;
    localparam int C_CPOL = 7;

    typedef enum logic [2:0] {
        S_IDLE, S_LEAD, S_SHIFT, S_TRAIL, S_GAP
    } eng_st_e;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               rdata,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       full,
    output logic                       empty
);
    localparam int LW = $clog2(DEPTH + 1);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LASTP = PW'(DEPTH - 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [LW-1:0] cnt;
    } ptr_t;

    ptr_t q, d;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign full    = (q.cnt == LW'(DEPTH));
    assign empty   = (q.cnt == '0);
    assign level   = q.cnt;
    assign rdata   = mem[q.rp];
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;

    always_comb begin
        d = q;
        if (flush) begin
            d = '0;
        end else begin
            if (do_push) d.wp = (q.wp == LASTP) ? '0 : q.wp + 1'b1;
            if (do_pop)  d.rp = (q.rp == LASTP) ? '0 : q.rp + 1'b1;
            if (do_push && !do_pop) d.cnt = q.cnt + 1'b1;
            if (do_pop && !do_push) d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wp] <= wdata;
    end

    // R10: a push into a full FIFO leaves the level unchanged
    a_r10_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (level == $past(level)));

    a_r10_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));
endmodule

// File: rtl/spim_engine.sv
module spim_engine import spim_pkg::*; (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] half,
    input  logic [3:0]    nlast,
    input  logic          cpol,
    input  logic          cpha,
    input  logic          tx_valid,
    input  logic [DW-1:0] tx_data,
    output logic          tx_pop,
    output logic          rx_push,
    output logic [DW-1:0] rx_data,
    input  logic          miso,
    output logic          sclk,
    output logic          mosi,
    output logic          ss_active
);
    typedef struct packed {
        eng_st_e       st;
        logic [CW-1:0] cnt;
        logic [4:0]    edg;
        logic          sclk;
        logic          ss;
        logic [DW-1:0] tsh;
        logic [DW-1:0] rsh;
    } eng_t;

    eng_t q, d;
    logic tick, lead, samp;
    logic [DW-1:0] load_w;

    assign tick      = (q.cnt == half - 1'b1);
    assign lead      = !q.edg[0];
    assign samp      = lead ^ cpha;
    assign load_w    = tx_data << (4'd15 - nlast);
    assign rx_data   = q.rsh & (16'hFFFF >> (4'd15 - nlast));
    assign sclk      = q.sclk;
    assign mosi      = q.tsh[DW-1];
    assign ss_active = q.ss;

    always_comb begin
        d       = q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        if (!en) begin
            d.st   = S_IDLE;
            d.cnt  = '0;
            d.edg  = '0;
            d.sclk = cpol;
            d.ss   = 1'b0;
        end else begin
            unique case (q.st)
                S_IDLE: begin
                    d.sclk = cpol;
                    if (tx_valid && half != '0) begin
                        tx_pop = 1'b1;
                        d.tsh  = load_w;
                        d.ss   = 1'b1;
                        d.st   = S_LEAD;
                        d.cnt  = '0;
                    end
                end
                S_LEAD: begin
                    d.cnt = q.cnt + 1'b1;
                    if (tick) begin
                        d.st  = S_SHIFT;
                        d.cnt = '0;
                        d.edg = '0;
                    end
                end
                S_SHIFT: begin
                    d.cnt = q.cnt + 1'b1;
                    if (tick) begin
                        d.cnt  = '0;
                        d.sclk = !q.sclk;
                        d.edg  = q.edg + 1'b1;
                        if (samp)                d.rsh = {q.rsh[DW-2:0], miso};
                        else if (q.edg != '0)    d.tsh = q.tsh << 1;
                        if (q.edg == {nlast, 1'b1}) d.st = S_TRAIL;
                    end
                end
                S_TRAIL: begin
                    d.cnt = q.cnt + 1'b1;
                    if (tick) begin
                        rx_push = 1'b1;
                        d.cnt   = '0;
                        if (cpha && tx_valid) begin
                            tx_pop = 1'b1;
                            d.tsh  = load_w;
                            d.edg  = '0;
                            d.st   = S_SHIFT;
                        end else begin
                            d.ss = 1'b0;
                            d.st = S_GAP;
                        end
                    end
                end
                default: begin
                    d.cnt = q.cnt + 1'b1;
                    if (tick) begin
                        d.cnt = '0;
                        d.st  = S_IDLE;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: S_IDLE, default: '0};
        else        q <= d;
    end

    // R3: with select released, SCLK rests at the polarity level
    a_r3_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !q.ss) |-> (q.sclk == cpol));

    // R4: a stopped divider never starts a frame
    a_r4_stopped_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_IDLE && half == '0) |=> !q.ss);

    // R2: a received word is only produced at the end of a selected frame
    a_r2_push_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> (q.ss && q.st == S_TRAIL));

    // R6: select is never released while edges are still being produced
    a_r6_select_held_in_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_SHIFT) |-> q.ss);
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master import spim_pkg::*; #(
    parameter int NSEL     = 4,
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [3:0]      reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            irq,
    output logic            sclk,
    output logic            mosi,
    input  logic            miso,
    output logic [NSEL-1:0] ss_n
);
    localparam int TLW = $clog2(TX_DEPTH + 1);
    localparam int RLW = $clog2(RX_DEPTH + 1);

    typedef struct packed {
        logic [9:0]      ctrl;
        logic            en;
        logic [NSEL-1:0] sel;
        logic [DW-1:0]   baud;
        logic [TLW-1:0]  thr;
        logic [1:0]      imask;
        logic            ovf;
    } regs_t;

    regs_t q, d;
    logic tx_push, tx_pop, tx_full, tx_empty;
    logic rx_push, rx_pop, rx_full, rx_empty;
    logic [DW-1:0] tx_head, rx_head, rx_word;
    logic [TLW-1:0] tx_lvl;
    logic [RLW-1:0] rx_lvl;
    logic [3:0] nlast;
    logic ss_on, busy;
    logic [5:0] status;
    logic [1:0] istat;

    assign nlast  = (q.ctrl[3:0] < 4'd3) ? 4'd3 : q.ctrl[3:0];
    assign busy   = ss_on || !tx_empty;
    assign status = {q.ovf, rx_full, !rx_empty, tx_empty, !tx_full, busy};
    assign istat  = {rx_full & q.imask[1], (tx_lvl <= q.thr) & q.imask[0]};
    assign irq    = |istat;
    assign ss_n   = ss_on ? ~q.sel : '1;

    always_comb begin
        d       = q;
        tx_push = 1'b0;
        rx_pop  = reg_rd && (reg_addr == A_DATA);
        if (reg_wr) begin
            unique case (reg_addr)
                A_CTRL: if (!q.en) d.ctrl = reg_wdata[9:0];
                A_EN:   d.en = reg_wdata[0];
                A_SEL:  if ($onehot0(reg_wdata[NSEL-1:0])) d.sel = reg_wdata[NSEL-1:0];
                A_BAUD: if (!q.en) d.baud = reg_wdata;
                A_THR:  d.thr = reg_wdata[TLW-1:0];
                A_MASK: d.imask = {reg_wdata[4], reg_wdata[0]};
                A_DATA: tx_push = q.en;
                default: ;
            endcase
        end
        if (rx_push && rx_full) d.ovf = 1'b1;
        if (!q.en)              d.ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{ctrl: 10'h007, default: '0};
        else        q <= d;
    end

    always_comb begin
        unique case (reg_addr)
            A_CTRL:   reg_rdata = DW'(q.ctrl);
            A_EN:     reg_rdata = DW'(q.en);
            A_SEL:    reg_rdata = DW'(q.sel);
            A_BAUD:   reg_rdata = q.baud;
            A_THR:    reg_rdata = DW'(q.thr);
            A_MASK:   reg_rdata = DW'({q.imask[1], 3'b000, q.imask[0]});
            A_TXLVL:  reg_rdata = DW'(tx_lvl);
            A_RXLVL:  reg_rdata = DW'(rx_lvl);
            A_STATUS: reg_rdata = DW'(status);
            A_ISTAT:  reg_rdata = DW'({istat[1], 3'b000, istat[0]});
            A_DATA:   reg_rdata = rx_empty ? '0 : rx_head;
            default:  reg_rdata = '0;
        endcase
    end

    spim_fifo #(.W(DW), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(!q.en), .push(tx_push), .wdata(reg_wdata),
        .pop(tx_pop), .rdata(tx_head), .level(tx_lvl), .full(tx_full), .empty(tx_empty));

    spim_fifo #(.W(DW), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(!q.en), .push(rx_push), .wdata(rx_word),
        .pop(rx_pop), .rdata(rx_head), .level(rx_lvl), .full(rx_full), .empty(rx_empty));

    spim_engine u_eng (
        .clk(clk), .rst_n(rst_n), .en(q.en), .half(q.baud[DW-1:1]), .nlast(nlast),
        .cpol(q.ctrl[C_CPOL]), .cpha(q.ctrl[C_CPHA]), .tx_valid(!tx_empty),
        .tx_data(tx_head), .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_word),
        .miso(miso), .sclk(sclk), .mosi(mosi), .ss_active(ss_on));

    // R5: at most one select line is driven low
    a_r5_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ss_n));

    // R12: control and divider are frozen while enabled
    a_r12_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (q.en && reg_wr && (reg_addr == A_CTRL || reg_addr == A_BAUD))
        |=> ($stable(q.ctrl) && $stable(q.baud)));

    // R11: the overflow flag persists until the master is disabled
    a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ovf && q.en) |=> q.ovf);

    // R14: an asserted select always reads as busy
    a_r14_busy_with_select: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_n != '1) |-> status[0]);

    // R13: a disabled master holds every select high one cycle later
    a_r13_disable_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.en && !$past(q.en)) |-> (ss_n == '1));
endmodule

// File: tb/spi_fifo_master_test.sv
`timescale 1ns/1ps
module spi_fifo_master_test;
    import spim_pkg::*;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic irq, sclk, mosi, miso = 1'b0;
    logic [3:0] ss_n;

    int nchk = 0, nfail = 0;

    spi_fifo_master uut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n));

    always #2 clk = ~clk;

    // behavioural slave
    logic cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    int cfg_n = 8;
    logic [15:0] slv_word = '0, sl_sh = '0, sl_rx = '0;
    logic [15:0] sl_log [16];
    int sl_bits = 0, nlog = 0, rel_cnt = 0, tgl_cnt = 0, min_gap = 1000;
    time t_rel = 0;
    bit t_rel_ok = 0;
    logic ss_act;
    assign ss_act = ~&ss_n;

    always @(posedge ss_act) begin
        sl_bits = 0;
        sl_sh = slv_word << (16 - cfg_n);
        miso = sl_sh[15];
        if (t_rel_ok && (($time - t_rel) / 4) < min_gap) min_gap = int'(($time - t_rel) / 4);
    end
    always @(negedge ss_act) begin
        rel_cnt++;
        t_rel = $time;
        t_rel_ok = 1;
    end
    always @(sclk) begin
        tgl_cnt++;
        if (ss_act) begin
            if ((sclk != cfg_cpol) ^ cfg_cpha) begin
                sl_rx = {sl_rx[14:0], mosi};
                sl_bits++;
                if (sl_bits == cfg_n) begin
                    if (nlog < 16) sl_log[nlog] = sl_rx & msk(cfg_n);
                    nlog++;
                    sl_bits = 0;
                    sl_sh = slv_word << (16 - cfg_n);
                    miso = sl_sh[15];
                end
            end else if (sl_bits != 0) begin
                sl_sh = sl_sh << 1;
                miso = sl_sh[15];
            end
        end
    end

    function automatic logic [15:0] msk(input int n);
        return 16'((32'h1 << n) - 1);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic cfg(input logic [15:0] ctrl, input logic [15:0] baud, input logic [3:0] sel, input int n);
        wr(A_EN, 16'h0);
        wr(A_CTRL, ctrl);
        wr(A_BAUD, baud);
        wr(A_SEL, {12'h0, sel});
        cfg_cpol = ctrl[C_CPOL]; cfg_cpha = ctrl[C_CPHA]; cfg_n = n;
        nlog = 0;
        wr(A_EN, 16'h1);
    endtask

    task automatic wait_done();
        logic [15:0] s;
        for (int i = 0; i < 4000; i++) begin
            rd(A_STATUS, s);
            if (!s[0]) break;
        end
    endtask

    task automatic t_reset();
        logic [15:0] v;
        chk("R1 ss_n", ss_n, 4'hF);
        chk("R1 sclk", sclk, 0);
        chk("R1 irq", irq, 0);
        rd(A_STATUS, v); chk("R1 status", v, 16'h0006);
        rd(A_CTRL, v);   chk("R1 ctrl", v, 16'h0007);
        rd(A_TXLVL, v);  chk("R1 txlvl", v, 0);
        rd(A_RXLVL, v);  chk("R1 rxlvl", v, 0);
    endtask

    task automatic t_basic();
        logic [15:0] v;
        time t0, t1;
        cfg(16'h0007, 16'd4, 4'b0001, 8);
        slv_word = 16'h00A5;
        wr(A_DATA, 16'h003C);
        wait (ss_act);
        rd(A_STATUS, v); chk("R14 busy in frame", v[0], 1);
        @(sclk) t0 = $time;
        @(sclk) t1 = $time;
        chk("R4 half period", 32'(t1 - t0), 8);
        wait_done();
        chk("R6 released", ss_n, 4'hF);
        rd(A_STATUS, v); chk("R8 R14 status after", v, 16'h000E);
        chk("R2 mosi word", sl_log[0], 16'h003C);
        rd(A_DATA, v); chk("R2 rx word", v, 16'h00A5);
    endtask

    task automatic t_modes();
        logic [15:0] v, txw, ctrl;
        int n;
        for (int m = 0; m < 4; m++) begin
            n = (m == 0) ? 4 : (m == 1) ? 12 : (m == 2) ? 16 : 8;
            ctrl = {8'h0, m[1], m[0], 2'b00, (m == 0) ? 4'd1 : 4'(n - 1)};
            txw = 16'hB7D3 ^ 16'(m * 16'h1111);
            cfg(ctrl, 16'd6, 4'b0001, n);
            slv_word = 16'h5A3C ^ 16'(m * 16'h0F0F);
            wr(A_DATA, txw);
            wait_done();
            chk("R3 R2 mosi", sl_log[0], txw & msk(n));
            rd(A_DATA, v); chk("R3 R2 miso", v, slv_word & msk(n));
            chk("R3 idle level", sclk, m[1]);
        end
    endtask

    task automatic t_cpha1_burst();
        logic [15:0] v;
        int r0;
        cfg(16'h0047, 16'd4, 4'b0001, 8);
        slv_word = 16'h0096;
        r0 = rel_cnt;
        wr(A_DATA, 16'h0011); wr(A_DATA, 16'h0022); wr(A_DATA, 16'h0033);
        wait_done();
        chk("R6 one release", rel_cnt - r0, 1);
        chk("R6 frame0", sl_log[0], 16'h0011);
        chk("R6 frame2", sl_log[2], 16'h0033);
        rd(A_RXLVL, v); chk("R10 rxlvl", v, 3);
        rd(A_DATA, v); chk("R2 burst rx", v, 16'h0096);
    endtask

    task automatic t_cpha0_burst();
        int r0;
        cfg(16'h0007, 16'd4, 4'b0001, 8);
        slv_word = 16'h0069;
        r0 = rel_cnt; min_gap = 1000; t_rel_ok = 0;
        wr(A_DATA, 16'h0081); wr(A_DATA, 16'h0042); wr(A_DATA, 16'h0024);
        wait_done();
        chk("R7 releases", rel_cnt - r0, 3);
        chk("R7 gap", min_gap >= 2, 1);
        chk("R7 frame1", sl_log[1], 16'h0042);
    endtask

    task automatic t_stopped();
        logic [15:0] v;
        int t0;
        cfg(16'h0007, 16'd1, 4'b0001, 8);
        t0 = tgl_cnt;
        wr(A_DATA, 16'h0055);
        repeat (60) @(negedge clk);
        chk("R4 no select", ss_n, 4'hF);
        chk("R4 no sclk", tgl_cnt - t0, 0);
        rd(A_TXLVL, v); chk("R4 still queued", v, 1);
    endtask

    task automatic t_select();
        logic [15:0] v;
        cfg(16'h0007, 16'd4, 4'b0010, 8);
        wr(A_SEL, 16'h0003);
        rd(A_SEL, v); chk("R5 bad write ignored", v, 16'h0002);
        wr(A_DATA, 16'h0001);
        wait (ss_act);
        #1 chk("R5 line", ss_n, 4'b1101);
        wait_done();
    endtask

    task automatic t_status_irq();
        logic [15:0] v;
        cfg(16'h0007, 16'd0, 4'b0001, 8);
        wr(A_THR, 16'd1); wr(A_MASK, 16'h0011);
        wr(A_DATA, 16'h0001);
        rd(A_ISTAT, v); chk("R9 txe at threshold", v, 16'h0001);
        chk("R9 irq high", irq, 1);
        wr(A_DATA, 16'h0002);
        rd(A_ISTAT, v); chk("R9 above threshold", v, 0);
        chk("R9 irq low", irq, 0);
        rd(A_STATUS, v); chk("R8 R14 queued", v, 16'h0003);
        for (int i = 0; i < 7; i++) wr(A_DATA, 16'(i));
        rd(A_TXLVL, v); chk("R10 full level", v, 8);
        rd(A_STATUS, v); chk("R8 tx full", v, 16'h0001);
        wr(A_BAUD, 16'd8);
        rd(A_BAUD, v); chk("R12 baud locked", v, 0);
        wr(A_CTRL, 16'h00C3);
        rd(A_CTRL, v); chk("R12 ctrl locked", v, 16'h0007);
        wr(A_EN, 16'h0);
        rd(A_TXLVL, v); chk("R13 flushed", v, 0);
        wr(A_DATA, 16'h0077);
        rd(A_TXLVL, v); chk("R13 write when off", v, 0);
        wr(A_MASK, 16'h0);
    endtask

    task automatic t_overflow();
        logic [15:0] v;
        cfg(16'h0007, 16'd2, 4'b0001, 8);
        slv_word = 16'h00C3;
        for (int i = 0; i < 9; i++) wr(A_DATA, 16'(i + 1));
        wait_done();
        rd(A_RXLVL, v); chk("R11 rxlvl", v, 8);
        rd(A_STATUS, v); chk("R11 R8 status", v, 16'h003E);
        wr(A_MASK, 16'h0010);
        rd(A_ISTAT, v); chk("R9 rx full", v, 16'h0010);
        rd(A_DATA, v); chk("R11 kept word", v, 16'h00C3);
        wr(A_MASK, 16'h0);
        wr(A_EN, 16'h0);
        rd(A_STATUS, v); chk("R13 ovf cleared", v, 16'h0006);
    endtask

    task automatic t_abort();
        cfg(16'h00C7, 16'd40, 4'b0001, 8);
        wr(A_DATA, 16'h00F0);
        wait (ss_act);
        repeat (30) @(negedge clk);
        wr(A_EN, 16'h0);
        @(negedge clk);
        chk("R13 select idle", ss_n, 4'hF);
        chk("R13 sclk idle", sclk, 1);
    endtask

    initial begin
        #(4 * 150000);
        nfail++; nchk++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_modes();
        t_cpha1_burst();
        t_cpha0_burst();
        t_stopped();
        t_select();
        t_status_irq();
        t_overflow();
        t_abort();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule